// File: doc/BRIEF.md
# Latched Interrupt Source and Pin Controller

This block gathers two kinds of events, a new acceleration sample and a detected motion event, into latched source flags. It presents them as three read-only byte values (a source byte, an axis/direction byte and a status byte) and drives one physical interrupt pin. A register interface elsewhere decodes the bus. It hands this block two one-cycle read strobes: one when the acceleration data bytes are read, and one when the release location is read. The motion detector and the bus logic sit outside.

The pin has three controls. An enable bit holds the pin at its inactive level when it is 0. A polarity bit selects the active level. A response bit selects between a level that follows the latched flags and a fixed-width pulse per event. In pulse mode a motion event fires once and then stays silent until a release read re-arms it. The pulse width is a parameter counted in system clocks: `PULSE_US` microseconds at `CLK_HZ`. The defaults are 40 µs at 125 MHz, which is 5000 cycles.

All state changes on the rising clock edge. A strobe presented before edge N shows on the outputs right after edge N.

Top module: `evt_irq_ctrl`

## Requirements
- R1: During and after a synchronous reset all three bytes read 0, and `irq_pin` sits at its inactive level, which is the inverse of `pin_act_high`.
- R2: When `sample_stb` and `drdy_rpt_en` are both 1, bit 4 of `src_byte` (data ready) is 1 after that edge. With `drdy_rpt_en` at 0 a sample leaves the flag unchanged.
- R3: The data-ready flag clears on either `data_rd_stb` or `release_rd_stb`. A new accepted sample in the same cycle wins, so the flag stays 1.
- R4: A `motion_stb` sets bit 1 of `src_byte` and ORs `motion_axes` into `axis_byte[5:0]`. The bit order in both vectors is, from bit 5 down to bit 0: X-, X+, Y-, Y+, Z-, Z+. Only `release_rd_stb` clears them, and `data_rd_stb` has no effect on them. A motion event in the release cycle reloads the flag and the byte with the new axes.
- R5: Bit 4 of `stat_byte` is set by any accepted event, either a data-ready set or a motion event. It clears on `data_rd_stb` or `release_rd_stb`, and an event in the same cycle wins.
- R6: Every bit of the three bytes that is not named in R2 to R5 reads 0: `src_byte` bits 7, 6, 5, 3, 2 and 0, `axis_byte` bits 7:6, and `stat_byte` bits other than 4.
- R7: In latched mode (`pin_pulse` = 0) with `pin_en` = 1, `irq_pin` is at the active level exactly while the data-ready flag or the motion flag is set. The active level is high when `pin_act_high` = 1 and low when it is 0.
- R8: In pulse mode with `pin_en` = 1, each accepted data-ready set drives the pin active for exactly `PULSE_US*CLK_HZ/1e6` cycles. A new trigger during a pulse restarts the count.
- R9: In pulse mode a motion event triggers a pulse only when the motion flag was clear before it. Further motion events stay silent until a release read.
- R10: With `pin_en` = 0, `irq_pin` holds the inactive level while the flags and bytes keep updating as in R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | New acceleration sample available (one cycle) |
| drdy_rpt_en | input | 1 | Report new samples as data-ready events |
| motion_stb | input | 1 | Motion event detected (one cycle) |
| motion_axes | input | 6 | Axis/direction of the motion event, {X-,X+,Y-,Y+,Z-,Z+} |
| pin_en | input | 1 | Interrupt pin enable |
| pin_act_high | input | 1 | 1 = pin active high, 0 = active low |
| pin_pulse | input | 1 | 0 = level follows latched flags, 1 = pulse per event |
| data_rd_stb | input | 1 | Acceleration data bytes were read |
| release_rd_stb | input | 1 | Release location was read |
| src_byte | output | 8 | Source byte: bit 4 data ready, bit 1 motion |
| axis_byte | output | 8 | Motion axis/direction flags in bits 5:0 |
| stat_byte | output | 8 | Status byte: bit 4 any event |
| irq_pin | output | 1 | Registered physical interrupt output |

## Verification
Two situations are hard to reach from the ports: a pulse-mode motion event arriving while the motion flag is already latched, and a clear strobe landing in the same cycle as a new event. Random stimulus reaches both because it fires motion events far more often than release reads, and it fires samples and data reads at the same high rate, so collisions are common. The pulse width is shortened through the parameters, so that the bench can measure a whole pulse and a retrigger inside it. Directed sequences also walk through the disabled pin and both polarities.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int AXIS_W        = 6;
  localparam int BYTE_W        = 8;
  localparam int SRC_DRDY_BIT  = 4;
  localparam int SRC_MOT_BIT   = 1;
  localparam int STAT_ANY_BIT  = 4;

  typedef struct packed {
    logic              drdy;
    logic              motion;
    logic              any;
    logic [AXIS_W-1:0] axes;
  } src_state_t;
endpackage

// File: rtl/evt_src_latch.sv
module evt_src_latch
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_stb,
  input  logic              drdy_rpt_en,
  input  logic              motion_stb,
  input  logic [AXIS_W-1:0] motion_axes,
  input  logic              data_rd_stb,
  input  logic              release_rd_stb,
  output src_state_t        st_q,
  output src_state_t        st_d,
  output logic              drdy_trig,
  output logic              mot_trig
);
  logic drdy_set;

  assign drdy_set  = sample_stb & drdy_rpt_en;
  assign drdy_trig = drdy_set;
  // motion pulses only when not already latched
  assign mot_trig  = motion_stb & ~st_q.motion;

  always_comb begin
    st_d = st_q;
    if (data_rd_stb || release_rd_stb) begin
      st_d.drdy = 1'b0;
      st_d.any  = 1'b0;
    end
    if (release_rd_stb) begin
      st_d.motion = 1'b0;
      st_d.axes   = '0;
    end
    if (drdy_set) begin
      st_d.drdy = 1'b1;
      st_d.any  = 1'b1;
    end
    if (motion_stb) begin
      st_d.motion = 1'b1;
      st_d.any    = 1'b1;
      st_d.axes   = st_d.axes | motion_axes;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/evt_pulse_gen.sv
module evt_pulse_gen #(
  parameter int unsigned CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic active_nxt
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (trig)            cnt_d = LOAD;
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    else                 cnt_d = '0;
  end

  assign active_nxt = (cnt_d != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/evt_pin_drive.sv
module evt_pin_drive (
  input  logic clk,
  input  logic rst,
  input  logic pin_en,
  input  logic pin_act_high,
  input  logic pin_pulse,
  input  logic level_nxt,
  input  logic pulse_nxt,
  output logic pin_q
);
  logic act;
  logic pin_d;

  always_comb begin
    act   = pin_pulse ? pulse_nxt : level_nxt;
    pin_d = (pin_en && act) ? pin_act_high : ~pin_act_high;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= ~pin_act_high;
    else     pin_q <= pin_d;
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 125_000_000,
  parameter int unsigned PULSE_US = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sample_stb,
  input  logic       drdy_rpt_en,
  input  logic       motion_stb,
  input  logic [5:0] motion_axes,
  input  logic       pin_en,
  input  logic       pin_act_high,
  input  logic       pin_pulse,
  input  logic       data_rd_stb,
  input  logic       release_rd_stb,
  output logic [7:0] src_byte,
  output logic [7:0] axis_byte,
  output logic [7:0] stat_byte,
  output logic       irq_pin
);
  localparam int unsigned PULSE_CYC = (CLK_HZ / 1_000_000) * PULSE_US;

  src_state_t st_q, st_d;
  logic drdy_trig, mot_trig, pulse_nxt;

  evt_src_latch u_latch (
    .clk(clk), .rst(rst),
    .sample_stb(sample_stb), .drdy_rpt_en(drdy_rpt_en),
    .motion_stb(motion_stb), .motion_axes(motion_axes),
    .data_rd_stb(data_rd_stb), .release_rd_stb(release_rd_stb),
    .st_q(st_q), .st_d(st_d),
    .drdy_trig(drdy_trig), .mot_trig(mot_trig)
  );

  evt_pulse_gen #(.CYCLES(PULSE_CYC)) u_pulse (
    .clk(clk), .rst(rst),
    .trig(drdy_trig | mot_trig),
    .active_nxt(pulse_nxt)
  );

  evt_pin_drive u_pin (
    .clk(clk), .rst(rst),
    .pin_en(pin_en), .pin_act_high(pin_act_high), .pin_pulse(pin_pulse),
    .level_nxt(st_d.drdy | st_d.motion),
    .pulse_nxt(pulse_nxt),
    .pin_q(irq_pin)
  );

  always_comb begin
    src_byte               = '0;
    src_byte[SRC_DRDY_BIT] = st_q.drdy;
    src_byte[SRC_MOT_BIT]  = st_q.motion;
    axis_byte              = {{(BYTE_W-AXIS_W){1'b0}}, st_q.axes};
    stat_byte              = '0;
    stat_byte[STAT_ANY_BIT] = st_q.any;
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sample_stb,
  input logic       drdy_rpt_en,
  input logic       motion_stb,
  input logic       pin_en,
  input logic       pin_act_high,
  input logic       pin_pulse,
  input logic       data_rd_stb,
  input logic       release_rd_stb,
  input logic [7:0] src_byte,
  input logic [7:0] axis_byte,
  input logic [7:0] stat_byte,
  input logic       irq_pin
);
  // R2: a sample with reporting disabled cannot raise data ready
  p_drdy_gated_r2: assert property (@(posedge clk) disable iff (rst)
    (!src_byte[4] && !(sample_stb && drdy_rpt_en)) |=> !src_byte[4]);

  // R3: a data read without a new accepted sample clears data ready
  p_drdy_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (data_rd_stb && !(sample_stb && drdy_rpt_en)) |=> !src_byte[4]);

  // R4: motion flag holds until a release read
  p_motion_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (src_byte[1] && !release_rd_stb) |=> (src_byte[1] && $stable(axis_byte[5:0]) | motion_stb_d));

  // R4: release without a motion event empties the axis byte
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (release_rd_stb && !motion_stb) |=> (axis_byte == 8'h00 && !src_byte[1]));

  // R5: status clears on a read when nothing new arrives
  p_stat_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ((data_rd_stb || release_rd_stb) && !motion_stb && !(sample_stb && drdy_rpt_en))
      |=> !stat_byte[4]);

  // R6: unnamed bits always read zero
  p_reserved_r6: assert property (@(posedge clk) disable iff (rst)
    ((src_byte & 8'hED) == 8'h00) && (axis_byte[7:6] == 2'b00) && ((stat_byte & 8'hEF) == 8'h00));

  // R7: latched mode pin tracks flags with the selected polarity
  p_level_pin_r7: assert property (@(posedge clk) disable iff (rst)
    (pin_en && !pin_pulse) |=>
      (irq_pin == ($past(pin_act_high) ? (src_byte[4] | src_byte[1]) : !(src_byte[4] | src_byte[1]))));

  // R10: disabled pin sits at the inactive level
  p_disabled_pin_r10: assert property (@(posedge clk) disable iff (rst)
    !pin_en |=> (irq_pin != $past(pin_act_high)));

  logic motion_stb_d;
  always_ff @(posedge clk) begin
    if (rst) motion_stb_d <= 1'b0;
    else     motion_stb_d <= motion_stb;
  end
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst),
  .sample_stb(sample_stb), .drdy_rpt_en(drdy_rpt_en), .motion_stb(motion_stb),
  .pin_en(pin_en), .pin_act_high(pin_act_high), .pin_pulse(pin_pulse),
  .data_rd_stb(data_rd_stb), .release_rd_stb(release_rd_stb),
  .src_byte(src_byte), .axis_byte(axis_byte), .stat_byte(stat_byte),
  .irq_pin(irq_pin)
);

// File: tb/test_evt_irq_ctrl.sv
`timescale 1ns/1ps
module test_evt_irq_ctrl;
  localparam int unsigned T_CLK_HZ   = 1_000_000;
  localparam int unsigned T_PULSE_US = 12;
  localparam int unsigned PW = (T_CLK_HZ / 1_000_000) * T_PULSE_US;

  logic clk = 1'b0;
  logic rst;
  logic sample_stb, drdy_rpt_en, motion_stb;
  logic [5:0] motion_axes;
  logic pin_en, pin_act_high, pin_pulse, data_rd_stb, release_rd_stb;
  logic [7:0] src_byte, axis_byte, stat_byte;
  logic irq_pin;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // model state
  bit m_drdy, m_mot, m_any;
  bit [5:0] m_axes;
  int m_cnt;
  bit m_pin;

  always #4 clk = ~clk;

  evt_irq_ctrl #(.CLK_HZ(T_CLK_HZ), .PULSE_US(T_PULSE_US)) i_evt_irq_ctrl (
    .clk(clk), .rst(rst),
    .sample_stb(sample_stb), .drdy_rpt_en(drdy_rpt_en),
    .motion_stb(motion_stb), .motion_axes(motion_axes),
    .pin_en(pin_en), .pin_act_high(pin_act_high), .pin_pulse(pin_pulse),
    .data_rd_stb(data_rd_stb), .release_rd_stb(release_rd_stb),
    .src_byte(src_byte), .axis_byte(axis_byte), .stat_byte(stat_byte),
    .irq_pin(irq_pin)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pin_level(bit en, bit hi, bit act);
    return (en && act) ? hi : !hi;
  endfunction

  // compute next model state from the requirements
  task automatic model_step();
    bit acc, trig;
    acc  = sample_stb && drdy_rpt_en;
    trig = acc || (motion_stb && !m_mot);
    if (rst) begin
      m_drdy = 0; m_mot = 0; m_any = 0; m_axes = '0; m_cnt = 0;
      m_pin = !pin_act_high;
      return;
    end
    if (data_rd_stb || release_rd_stb) begin m_drdy = 0; m_any = 0; end
    if (release_rd_stb) begin m_mot = 0; m_axes = '0; end
    if (acc) begin m_drdy = 1; m_any = 1; end
    if (motion_stb) begin m_mot = 1; m_any = 1; m_axes = m_axes | motion_axes; end
    if (trig) m_cnt = PW; else if (m_cnt > 0) m_cnt--;
    m_pin = pin_level(pin_en, pin_act_high, pin_pulse ? (m_cnt != 0) : (m_drdy || m_mot));
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    #1;
    check("R2/R3 data-ready bit", {7'd0, src_byte[4]}, {7'd0, m_drdy});
    check("R4 motion bit", {7'd0, src_byte[1]}, {7'd0, m_mot});
    check("R4 axis byte", axis_byte, {2'b00, m_axes});
    check("R5 status bit", {7'd0, stat_byte[4]}, {7'd0, m_any});
    check("R6 reserved bits", {src_byte & 8'hED} | {stat_byte & 8'hEF}, 8'h00);
    if (!pin_en)        check("R10 pin disabled", {7'd0, irq_pin}, {7'd0, m_pin});
    else if (pin_pulse) check("R8/R9 pulse pin", {7'd0, irq_pin}, {7'd0, m_pin});
    else                check("R7 level pin", {7'd0, irq_pin}, {7'd0, m_pin});
    @(negedge clk);
    sample_stb = 0; motion_stb = 0; data_rd_stb = 0; release_rd_stb = 0; motion_axes = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int pw_seen;
    void'($urandom(32'd20240611));
    rst = 1; sample_stb = 0; drdy_rpt_en = 0; motion_stb = 0; motion_axes = '0;
    pin_en = 0; pin_act_high = 1; pin_pulse = 0; data_rd_stb = 0; release_rd_stb = 0;
    @(negedge clk);
    step(); step();
    // R1: reset state
    check("R1 reset src", src_byte, 8'h00);
    check("R1 reset axis", axis_byte, 8'h00);
    check("R1 reset stat", stat_byte, 8'h00);
    check("R1 reset pin", {7'd0, irq_pin}, 8'h00);
    rst = 0;

    // R2: disabled reporting ignores samples
    sample_stb = 1; step();
    check("R2 sample ignored", src_byte, 8'h00);
    // R7 active-low latched level
    pin_en = 1; pin_act_high = 0; drdy_rpt_en = 1;
    sample_stb = 1; step();
    check("R7 active-low asserted", {7'd0, irq_pin}, 8'h00);
    // R3 coincident set and clear: set wins
    sample_stb = 1; data_rd_stb = 1; step();
    check("R3 set wins", {7'd0, src_byte[4]}, 8'h01);
    data_rd_stb = 1; step();
    // R4: data read leaves motion
    motion_stb = 1; motion_axes = 6'b100001; step();
    motion_stb = 1; motion_axes = 6'b000100; step();
    data_rd_stb = 1; step();
    check("R4 data read keeps axes", axis_byte, 8'h25);
    release_rd_stb = 1; motion_stb = 1; motion_axes = 6'b010000; step();
    check("R4 release reload", axis_byte, 8'h10);
    release_rd_stb = 1; step();

    // R8: pulse width, active high
    pin_act_high = 1; pin_pulse = 1; idle(2);
    sample_stb = 1; step();
    pw_seen = 0;
    while (irq_pin && pw_seen < 100) begin pw_seen++; step(); end
    check("R8 pulse width", 8'(pw_seen), 8'(PW));
    // R9: motion pulses once until release
    motion_stb = 1; motion_axes = 6'b000010; step();
    idle(PW + 2);
    motion_stb = 1; motion_axes = 6'b000010; step();
    check("R9 no re-pulse", {7'd0, irq_pin}, 8'h00);
    release_rd_stb = 1; step();
    motion_stb = 1; step();
    check("R9 re-armed pulse", {7'd0, irq_pin}, 8'h01);
    // R10: disabled pin while sources update
    pin_en = 0; idle(PW);
    sample_stb = 1; step();
    check("R10 source still set", {7'd0, src_byte[4]}, 8'h01);

    // random phase
    for (int k = 0; k < 6000; k++) begin
      if ((k % 300) == 0) begin
        drdy_rpt_en  = ($urandom % 4) != 0;
        pin_en       = ($urandom % 4) != 0;
        pin_act_high = $urandom % 2;
        pin_pulse    = $urandom % 2;
      end
      sample_stb     = ($urandom % 8) == 0;
      motion_stb     = ($urandom % 10) == 0;
      motion_axes    = 6'($urandom);
      data_rd_stb    = ($urandom % 8) == 0;
      release_rd_stb = ($urandom % 40) == 0;
      step();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule